// File: doc/BRIEF.md
# Electronic Shutter Pulse Sequencer

This block schedules the substrate discharge pulses that empty an image sensor before exposure, and it raises an exposure flag that marks the interval during which charge is collected. It works in terms of lines and fields. A vertical strobe starts each field at line 0, and each horizontal strobe starts the next line. Software stages a configuration: an enable bit, a field count, a line count and a selected-field index. The block adopts that configuration at the first field of each exposure period.

With a field count of zero the block runs a high-speed shutter, which places a group of discharge pulses in every field. With a non-zero field count it runs a low-speed shutter. The exposure then spans the field count plus one fields, the pulses fall only in the selected field, and writes to the staged configuration are refused until the exposure ends at the readout strobe of the last field. Each pulse is one clock wide. The pulses occupy the lines just before the readout line, which is a parameter.

Top module: `shutter_seq`

## Requirements
- R1: After reset, `sub_pulse`, `exp_flag`, `exp_done` and `load_lock` are all 0.
- R2: While the active configuration has `cfg_en` = 0, no discharge pulse is produced, whatever the other fields hold.
- R3: Bit 11 of `cfg_hcnt` is ignored. Only bits 10..0 set the line count.
- R4: In a field that carries pulses, exactly one pulse occurs in each line L with L < RD_LINE and L + hcnt + 1 >= RD_LINE. That is hcnt+1 pulses, clipped at line 0. Each pulse is high for the single cycle after the strobe that starts its line.
- R5: With `cfg_vcnt` = 0 (high-speed shutter), every field carries pulses, and each field is a whole exposure period.
- R6: With `cfg_vcnt` = V > 0 (low-speed shutter), the period lasts V+1 fields, indexed 0..V from its first vertical strobe. Pulses occur only in the field whose index equals `cfg_sel`. If `cfg_sel` > V, no field carries pulses.
- R7: `exp_flag` rises in the cycle in which the pulse of line RD_LINE-1 falls.
- R8: A `rdo_stb` in the last field of a period clears `exp_flag` and raises `exp_done` for one cycle, both in the next cycle. A `rdo_stb` in any other field has no effect.
- R9: If a period carries no pulse (shutter off, or `cfg_sel` > V), `exp_flag` rises one cycle after the strobe that starts line TENT_LINE of field 0.
- R10: A vertical strobe that starts a period whose adopted configuration is low-speed sets `load_lock`. `exp_done` clears it. While `load_lock` is 1, `cfg_wr` is ignored.
- R11: A configuration that is written is adopted at the vertical strobe that starts the next period, and it affects only pulses from that field on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vs_stb | input | 1 | Field start strobe (also starts line 0) |
| hs_stb | input | 1 | Line start strobe |
| rdo_stb | input | 1 | End of the readout pulse |
| cfg_wr | input | 1 | Stage the configuration inputs |
| cfg_en | input | 1 | Shutter enable |
| cfg_vcnt | input | 10 | Extra fields in the exposure (0 = high speed) |
| cfg_hcnt | input | 12 | Pulse line count minus one; bit 11 unused |
| cfg_sel | input | 10 | Field index that carries the pulses in low-speed mode |
| sub_pulse | output | 1 | Discharge pulse, one cycle per selected line |
| exp_flag | output | 1 | High while charge is being collected |
| exp_done | output | 1 | One-cycle end-of-exposure marker |
| load_lock | output | 1 | Configuration writes are refused |

## Verification
The bench runs fields with the shutter off, with a high-speed shutter at a small line count and at a count larger than the readout line, and with the dummy bit set. These show the gating, the clipping at line 0, and that the top bit is ignored. A three-field low-speed period with the middle field selected tests field indexing and the lockout, because a write attempted inside that period must leave the next period unchanged. A period whose selected index lies past its end tests the tentative start of the flag. A readout strobe in a field that is not the last shows that the flag survives across field boundaries.

// File: rtl/shutter_pkg.sv
package shutter_pkg;

    localparam int VCNT_W = 10;
    localparam int HCNT_W = 11;
    localparam int HFIELD_W = 12;

    typedef struct packed {
        logic              en;
        logic [VCNT_W-1:0] vcnt;
        logic [HCNT_W-1:0] hcnt;
        logic [VCNT_W-1:0] sel;
    } shut_cfg_t;

    function automatic logic is_slow(shut_cfg_t c);
        return c.en && (c.vcnt != '0);
    endfunction

    function automatic logic [VCNT_W-1:0] final_field(shut_cfg_t c);
        return is_slow(c) ? c.vcnt : '0;
    endfunction

    function automatic logic pulseless(shut_cfg_t c);
        return !c.en || (is_slow(c) && (c.sel > c.vcnt));
    endfunction

endpackage

// File: rtl/shutter_cfg.sv
module shutter_cfg
    import shutter_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cfg_wr,
    input  shut_cfg_t cfg_in,
    input  logic      period_start,
    input  logic      done_d,
    output shut_cfg_t stage,
    output shut_cfg_t act,
    output shut_cfg_t nxt_act,
    output logic      lock
);
    always_comb nxt_act = period_start ? stage : act;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage <= '0;
            act   <= '0;
            lock  <= 1'b0;
        end else begin
            if (cfg_wr && !lock) stage <= cfg_in;
            act <= nxt_act;
            if (done_d) lock <= 1'b0;
            if (period_start && is_slow(stage)) lock <= 1'b1;
        end
    end
endmodule

// File: rtl/shutter_timebase.sv
module shutter_timebase
    import shutter_pkg::*;
#(
    parameter int LINE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vs_stb,
    input  logic              hs_stb,
    input  shut_cfg_t         act,
    output logic [VCNT_W-1:0] fcnt,
    output logic [LINE_W-1:0] lcnt,
    output logic [VCNT_W-1:0] nxt_fcnt,
    output logic [LINE_W-1:0] nxt_lcnt,
    output logic              line_start,
    output logic              period_start,
    output logic              last_fld
);
    localparam logic [LINE_W-1:0] LINE_MAX = '1;

    always_comb begin
        last_fld     = (fcnt == final_field(act));
        period_start = vs_stb && last_fld;
        line_start   = vs_stb || hs_stb;
        if (vs_stb) nxt_fcnt = last_fld ? '0 : fcnt + 1'b1;
        else        nxt_fcnt = fcnt;
        if (vs_stb)                           nxt_lcnt = '0;
        else if (hs_stb && lcnt != LINE_MAX)  nxt_lcnt = lcnt + 1'b1;
        else                                  nxt_lcnt = lcnt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fcnt <= '0;
            lcnt <= '0;
        end else begin
            fcnt <= nxt_fcnt;
            lcnt <= nxt_lcnt;
        end
    end
endmodule

// File: rtl/shutter_pulse.sv
module shutter_pulse
    import shutter_pkg::*;
#(
    parameter int LINE_W    = 8,
    parameter int RD_LINE   = 40,
    parameter int TENT_LINE = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_start,
    input  logic              last_fld,
    input  logic              rdo_stb,
    input  logic [LINE_W-1:0] lcnt,
    input  logic [LINE_W-1:0] nxt_lcnt,
    input  logic [VCNT_W-1:0] nxt_fcnt,
    input  shut_cfg_t         nxt_act,
    output logic              done_d,
    output logic              sub_pulse,
    output logic              exp_flag,
    output logic              exp_done
);
    localparam int SUM_W = ((LINE_W > HCNT_W) ? LINE_W : HCNT_W) + 2;
    localparam logic [LINE_W-1:0] RD_L   = LINE_W'(RD_LINE);
    localparam logic [LINE_W-1:0] LAST_L = LINE_W'(RD_LINE - 1);
    localparam logic [LINE_W-1:0] TENT_L = LINE_W'(TENT_LINE);
    localparam logic [SUM_W-1:0]  RD_S   = SUM_W'(RD_LINE);

    logic [SUM_W-1:0] reach;
    logic in_win, fld_ok, sub_d, tent, rise;

    always_comb begin
        reach  = SUM_W'(nxt_lcnt) + SUM_W'(nxt_act.hcnt) + SUM_W'(1);
        in_win = (nxt_lcnt < RD_L) && (reach >= RD_S);
        fld_ok = nxt_act.en && (!is_slow(nxt_act) || nxt_fcnt == nxt_act.sel);
        sub_d  = line_start && fld_ok && in_win;
        tent   = line_start && (nxt_lcnt == TENT_L) && (nxt_fcnt == '0)
                 && pulseless(nxt_act);
        rise   = (sub_pulse && lcnt == LAST_L) || tent;
        done_d = rdo_stb && last_fld;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sub_pulse <= 1'b0;
            exp_flag  <= 1'b0;
            exp_done  <= 1'b0;
        end else begin
            sub_pulse <= sub_d;
            exp_done  <= done_d;
            if (done_d)    exp_flag <= 1'b0;
            else if (rise) exp_flag <= 1'b1;
        end
    end
endmodule

// File: rtl/shutter_seq.sv
module shutter_seq
    import shutter_pkg::*;
#(
    parameter int LINE_W    = 8,
    parameter int RD_LINE   = 40,
    parameter int TENT_LINE = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                vs_stb,
    input  logic                hs_stb,
    input  logic                rdo_stb,
    input  logic                cfg_wr,
    input  logic                cfg_en,
    input  logic [VCNT_W-1:0]   cfg_vcnt,
    input  logic [HFIELD_W-1:0] cfg_hcnt,
    input  logic [VCNT_W-1:0]   cfg_sel,
    output logic                sub_pulse,
    output logic                exp_flag,
    output logic                exp_done,
    output logic                load_lock
);
    shut_cfg_t cfg_in, stage, act, nxt_act;
    logic [VCNT_W-1:0] fcnt, nxt_fcnt;
    logic [LINE_W-1:0] lcnt, nxt_lcnt;
    logic line_start, period_start, last_fld, done_d;

    always_comb begin
        cfg_in.en   = cfg_en;
        cfg_in.vcnt = cfg_vcnt;
        cfg_in.hcnt = cfg_hcnt[HCNT_W-1:0];
        cfg_in.sel  = cfg_sel;
    end

    shutter_cfg u_cfg (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_in(cfg_in),
        .period_start(period_start), .done_d(done_d),
        .stage(stage), .act(act), .nxt_act(nxt_act), .lock(load_lock)
    );

    shutter_timebase #(.LINE_W(LINE_W)) u_tb (
        .clk(clk), .rst(rst), .vs_stb(vs_stb), .hs_stb(hs_stb), .act(act),
        .fcnt(fcnt), .lcnt(lcnt), .nxt_fcnt(nxt_fcnt), .nxt_lcnt(nxt_lcnt),
        .line_start(line_start), .period_start(period_start), .last_fld(last_fld)
    );

    shutter_pulse #(.LINE_W(LINE_W), .RD_LINE(RD_LINE), .TENT_LINE(TENT_LINE)) u_pulse (
        .clk(clk), .rst(rst), .line_start(line_start), .last_fld(last_fld),
        .rdo_stb(rdo_stb), .lcnt(lcnt), .nxt_lcnt(nxt_lcnt), .nxt_fcnt(nxt_fcnt),
        .nxt_act(nxt_act), .done_d(done_d), .sub_pulse(sub_pulse),
        .exp_flag(exp_flag), .exp_done(exp_done)
    );
endmodule

// File: rtl/shutter_seq_chk.sv
module shutter_seq_chk
    import shutter_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      vs_stb,
    input logic      hs_stb,
    input logic      rdo_stb,
    input logic      sub_pulse,
    input logic      exp_flag,
    input logic      exp_done,
    input logic      load_lock,
    input shut_cfg_t act,
    input shut_cfg_t stage
);
    AST_PULSE_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        sub_pulse |-> $past(vs_stb || hs_stb));                       // R4
    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
        sub_pulse |-> act.en);                                        // R2
    AST_DONE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
        exp_done |-> !exp_flag);                                      // R8
    AST_DONE_FROM_READOUT: assert property (@(posedge clk) disable iff (rst)
        exp_done |-> $past(rdo_stb));                                 // R8
    AST_LOCK_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $fell(load_lock) |-> exp_done);                               // R10
    AST_STAGE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (load_lock && $past(load_lock)) |-> $stable(stage));          // R10
    AST_FLAG_RISE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(exp_flag) |-> ($past(sub_pulse) || $past(vs_stb || hs_stb))); // R7
endmodule

bind shutter_seq shutter_seq_chk u_chk (
    .clk(clk), .rst(rst), .vs_stb(vs_stb), .hs_stb(hs_stb), .rdo_stb(rdo_stb),
    .sub_pulse(sub_pulse), .exp_flag(exp_flag), .exp_done(exp_done),
    .load_lock(load_lock), .act(act), .stage(stage)
);

// File: tb/shutter_seq_test.sv
module shutter_seq_test;
    localparam int RD = 40;
    localparam int TENT = 8;
    localparam int NLINES = 48;
    localparam int RDO_LINE = 41;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic vs = 0, hs = 0, rdo = 0, wr = 0, en = 0;
    logic [9:0] vc = 0, sel = 0;
    logic [11:0] hc = 0;
    logic sub_pulse, exp_flag, exp_done, load_lock;

    int checks = 0, failures = 0, sub_cnt = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    shutter_seq uut (
        .clk(clk), .rst(rst), .vs_stb(vs), .hs_stb(hs), .rdo_stb(rdo),
        .cfg_wr(wr), .cfg_en(en), .cfg_vcnt(vc), .cfg_hcnt(hc), .cfg_sel(sel),
        .sub_pulse(sub_pulse), .exp_flag(exp_flag), .exp_done(exp_done),
        .load_lock(load_lock)
    );

    // behavioural reference
    int s_en, s_v, s_h, s_sel, a_en, a_v, a_h, a_sel;
    int m_f, m_l;
    bit m_sub, m_flag, m_done, m_lock;

    always @(posedge clk) begin : model
        int last, nl, nf, n_en, n_v, n_h, n_sel;
        bit lf, st, dn, ls, win, fok, tent, rise, nsub;
        if (rst) begin
            s_en = 0; s_v = 0; s_h = 0; s_sel = 0;
            a_en = 0; a_v = 0; a_h = 0; a_sel = 0;
            m_f = 0; m_l = 0; m_sub = 0; m_flag = 0; m_done = 0; m_lock = 0;
        end else begin
            last = (a_en != 0 && a_v != 0) ? a_v : 0;
            lf = (m_f == last);
            st = vs && lf;
            dn = rdo && lf;
            ls = vs || hs;
            if (st) begin n_en = s_en; n_v = s_v; n_h = s_h; n_sel = s_sel; end
            else begin n_en = a_en; n_v = a_v; n_h = a_h; n_sel = a_sel; end
            nf = vs ? (lf ? 0 : m_f + 1) : m_f;
            nl = vs ? 0 : (hs ? ((m_l < 255) ? m_l + 1 : 255) : m_l);
            win = (nl < RD) && (nl + n_h + 1 >= RD);
            fok = (n_en != 0) && (n_v == 0 || nf == n_sel);
            nsub = ls && fok && win;
            tent = ls && nl == TENT && nf == 0 && (n_en == 0 || (n_v != 0 && n_sel > n_v));
            rise = (m_sub && m_l == RD - 1) || tent;
            if (dn) m_flag = 0; else if (rise) m_flag = 1;
            if (st && s_en != 0 && s_v != 0) begin
                if (wr && !m_lock) begin
                    s_en = en; s_v = vc; s_h = hc & 12'h7FF; s_sel = sel;
                end
                m_lock = 1;
            end else begin
                if (wr && !m_lock) begin
                    s_en = en; s_v = vc; s_h = hc & 12'h7FF; s_sel = sel;
                end
                if (dn) m_lock = 0;
            end
            a_en = n_en; a_v = n_v; a_h = n_h; a_sel = n_sel;
            m_f = nf; m_l = nl; m_sub = nsub; m_done = dn;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check(sub_pulse == m_sub, "R4 sub_pulse vs model", sub_pulse, m_sub);
            check(exp_flag == m_flag, "R7 exp_flag vs model", exp_flag, m_flag);
            check(exp_done == m_done, "R8 exp_done vs model", exp_done, m_done);
            check(load_lock == m_lock, "R10 load_lock vs model", load_lock, m_lock);
            if (sub_pulse) sub_cnt++;
        end
    end

    task automatic put_cfg(input bit e, input int v, input int h, input int s);
        @(negedge clk);
        wr = 1; en = e; vc = 10'(v); hc = 12'(h); sel = 10'(s);
        @(negedge clk);
        wr = 0;
    endtask

    task automatic run_field(output int cnt, output bit flag30, output bit lock20);
        sub_cnt = 0;
        flag30 = 0; lock20 = 0;
        for (int ln = 0; ln < NLINES; ln++) begin
            @(negedge clk);
            vs = (ln == 0); hs = (ln != 0);
            @(negedge clk);
            vs = 0; hs = 0;
            if (ln == RDO_LINE) rdo = 1;
            @(negedge clk);
            rdo = 0;
            if (ln == 30) flag30 = exp_flag;
            if (ln == 20) lock20 = load_lock;
            @(negedge clk);
        end
        cnt = sub_cnt;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int c; bit f, l;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check(sub_pulse == 0, "R1 sub_pulse", sub_pulse, 0);
        check(exp_flag == 0, "R1 exp_flag", exp_flag, 0);
        check(exp_done == 0, "R1 exp_done", exp_done, 0);
        check(load_lock == 0, "R1 load_lock", load_lock, 0);

        // R2 / R9: shutter off
        put_cfg(0, 0, 5, 0);
        for (int i = 0; i < 2; i++) begin
            run_field(c, f, l);
            check(c == 0, "R2 pulses with shutter off", c, 0);
            check(f == 1, "R9 tentative flag start", f, 1);
        end

        // R5 / R4 / R11: high speed, hcnt 5
        put_cfg(1, 0, 5, 0);
        for (int i = 0; i < 2; i++) begin
            run_field(c, f, l);
            check(c == 6, "R5 high-speed pulses per field", c, 6);
            check(f == 0, "R7 flag low before last pulse", f, 0);
            check(l == 0, "R10 no lock in high speed", l, 0);
        end

        // R3: dummy bit ignored
        put_cfg(1, 0, 12'h805, 0);
        run_field(c, f, l);
        check(c == 6, "R3 bit 11 ignored", c, 6);
        put_cfg(1, 0, 3, 0);
        run_field(c, f, l);
        check(c == 4, "R4 hcnt 3 gives 4 pulses", c, 4);

        // R4: clipping at line 0
        put_cfg(1, 0, 100, 0);
        run_field(c, f, l);
        check(c == RD, "R4 clipped pulse count", c, RD);

        // R6 / R10 / R8: low speed, 3 fields, middle selected
        put_cfg(1, 2, 3, 1);
        run_field(c, f, l);
        check(c == 0, "R6 field 0 silent", c, 0);
        check(l == 1, "R10 lock set in low speed", l, 1);
        put_cfg(0, 0, 7, 0);    // refused while locked
        run_field(c, f, l);
        check(c == 4, "R6 selected field pulses", c, 4);
        run_field(c, f, l);
        check(c == 0, "R6 field 2 silent", c, 0);
        check(f == 1, "R8 flag held across non-final readout", f, 1);
        check(load_lock == 0, "R10 lock released at done", load_lock, 0);
        for (int i = 0; i < 3; i++) begin
            run_field(c, f, l);
            check(c == ((i == 1) ? 4 : 0), "R10 locked write ignored", c, (i == 1) ? 4 : 0);
        end

        // R6 / R9: selected index beyond period
        put_cfg(1, 2, 3, 5);
        for (int i = 0; i < 3; i++) begin
            run_field(c, f, l);
            check(c == 0, "R6 sel beyond period", c, 0);
            if (i == 0) check(f == 1, "R9 tentative in low speed", f, 1);
        end

        // R11: new config adopted at next period
        put_cfg(1, 0, 5, 0);
        run_field(c, f, l);
        check(c == 6, "R11 config adopted", c, 6);

        repeat (4) @(negedge clk);
        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule